// File: doc/BRIEF.md
# Macro-Op Fusion Detector

This block looks at one 64-bit instruction fetch window from an 8/16-bit accumulator instruction stream. The window's first byte is the start of the next instruction. The block finds short fixed sequences of adjacent instructions that can issue together as one fused operation. For each window it emits one descriptor. The descriptor gives the fused-op kind, how many bytes it consumes, the 16-bit operand addresses it touches, whether carry-in is forced to zero, the address of the next instruction, and a predicted cycle cost.

Three sequences are recognised:

- clear-carry, load-absolute, add-absolute (a load followed by an add with a zero carry-in);
- store-absolute followed by load-absolute;
- add-absolute followed by store-absolute.

If a sequence does not match, or the window runs out of valid bytes before a sequence is complete, the block falls back to a single-instruction descriptor. The cost model charges one issue cycle and one cycle per memory operand. A 16-bit operand that straddles an 8-byte-aligned boundary adds a cycle. So does an instruction whose bytes reach past the valid part of the window.

Inputs are sampled on each rising clock edge and the descriptor is registered, so a decode takes one cycle. The block executes nothing and performs no memory access.

Top module: `fuse_detect`

## Requirements
- R1: While `rst_n` is low, and right after it falls, every output is zero: kind NONE (0), length 0, cost 0, operands 0, `carry_clr` 0, `next_addr` 0.
- R2: Byte k of the window sits in `win_data[8k+7:8k]`, and operands are little-endian. If byte0=0x18, byte1=0xAD and byte4=0x6D with at least 7 valid bytes, the result has the following fields, and this check has priority over the pairs:
  - kind ADD_FUSED (2) and length 7;
  - `carry_clr`=1;
  - `opnd_a`={byte3,byte2} and `opnd_b`={byte6,byte5}.
- R3: If byte0=0x8D and byte3=0xAD with at least 6 valid bytes, the result is kind STORE_LOAD (3) and length 6, with `opnd_a`={byte2,byte1} and `opnd_b`={byte5,byte4}.
- R4: If byte0=0x6D and byte3=0x8D with at least 6 valid bytes, the result is kind ADD_STORE (4) and length 6, with the operands taken as in R3.
- R5: When no sequence matches and at least one byte is valid, the result is kind SINGLE (1):
  - opcodes 0xAD, 0x6D and 0x8D have length 3 and `opnd_a`={byte2,byte1};
  - every other opcode has length 1 and operand 0;
  - `opnd_b` is 0 and `carry_clr` is 0.
- R6: Only the unbroken run of set `byte_valid` bits starting at bit 0 counts as valid, and bytes past that run read as zero. An empty run gives kind NONE with length 0 and cost 0.
- R7: Cost = 1 issue cycle + 1 per memory operand (two for each fused kind, one for a single absolute op, none otherwise). The clear-carry inside ADD_FUSED adds nothing.
- R8: Each memory operand whose address has bits [2:0]=7 adds one cycle when `acc16` is 1, and nothing when `acc16` is 0.
- R9: A single instruction whose length exceeds the valid run adds one cycle. Its missing operand bytes read as zero.
- R10: `next_addr` = `win_base` + length, modulo 2^16.
- R11: Outputs change only at the clock edge after the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_data | input | 64 | Fetch window, byte k in bits 8k+7:8k |
| byte_valid | input | 8 | Per-byte valid flags |
| win_base | input | 16 | Address of window byte 0 |
| acc16 | input | 1 | 16-bit accumulator mode |
| fused_kind | output | 3 | 0 NONE, 1 SINGLE, 2 ADD_FUSED, 3 STORE_LOAD, 4 ADD_STORE |
| fused_len | output | 4 | Bytes consumed |
| fused_cost | output | 4 | Predicted cycles |
| opnd_a | output | 16 | First memory operand address |
| opnd_b | output | 16 | Second memory operand address |
| carry_clr | output | 1 | Carry-in forced to zero |
| next_addr | output | 16 | Address after the consumed bytes |

## Verification
The hardest cases to reach from the ports sit on the edge of a match:

- a window that ends one byte short of a pair or the triple;
- a valid mask with a hole in it, which must shrink the usable run;
- a straddle on the second operand only.

The vector table builds each of these on purpose. It reuses a matching triple with masks of 0x3F and 0xF7, and it places operand addresses ending in 7 in either slot, with `acc16` both set and clear. A truncated single load at the top of the address space checks the zero-filled operand, the fetch penalty and the wrap of `next_addr` together.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

  localparam logic [7:0] OPC_CLC = 8'h18;
  localparam logic [7:0] OPC_LDA = 8'hAD;
  localparam logic [7:0] OPC_ADC = 8'h6D;
  localparam logic [7:0] OPC_STA = 8'h8D;

  localparam int OPND_W   = 16;
  localparam int ABS_LEN  = 3;
  localparam int TRI_LEN  = 7;
  localparam int PAIR_LEN = 6;

  typedef enum logic [2:0] {
    FK_NONE   = 3'd0,
    FK_SINGLE = 3'd1,
    FK_ADD    = 3'd2,
    FK_STLD   = 3'd3,
    FK_ADST   = 3'd4
  } fkind_e;

  // true for the three opcodes carrying a 16-bit absolute address
  function automatic logic is_abs(input logic [7:0] op);
    return (op == OPC_LDA) || (op == OPC_ADC) || (op == OPC_STA);
  endfunction

  // instruction length in bytes for the decoded subset
  function automatic logic [3:0] op_len(input logic [7:0] op);
    return is_abs(op) ? 4'(ABS_LEN) : 4'd1;
  endfunction

  // little-endian operand assembly
  function automatic logic [OPND_W-1:0] le16(input logic [7:0] lo, input logic [7:0] hi);
    return {hi, lo};
  endfunction

  // a wide access starting at the last byte of an 8-byte line crosses it
  function automatic logic crosses_line(input logic [OPND_W-1:0] addr, input logic wide);
    return wide && (addr[2:0] == 3'b111);
  endfunction

endpackage

// File: rtl/fuse_scan.sv
module fuse_scan #(
  parameter int WIN_BYTES = 8,
  localparam int CNT_W = $clog2(WIN_BYTES + 1)
) (
  input  logic [8*WIN_BYTES-1:0]     win_data,
  input  logic [WIN_BYTES-1:0]       byte_valid,
  output logic [WIN_BYTES-1:0][7:0]  win_bytes,
  output logic [CNT_W-1:0]           run_len
);

  logic [WIN_BYTES-1:0] run_ok;

  // prefix of contiguous valid bytes from byte 0
  always_comb begin
    logic             ok;
    logic [CNT_W-1:0] cnt;
    ok  = 1'b1;
    cnt = '0;
    for (int i = 0; i < WIN_BYTES; i++) begin
      ok        = ok & byte_valid[i];
      run_ok[i] = ok;
      if (ok) cnt = cnt + CNT_W'(1);
    end
    run_len = cnt;
  end

  // bytes outside the valid run read as zero
  for (genvar i = 0; i < WIN_BYTES; i++) begin : g_mask
    assign win_bytes[i] = run_ok[i] ? win_data[8*i +: 8] : 8'h00;
  end

endmodule

// File: rtl/fuse_match.sv
module fuse_match #(
  parameter int WIN_BYTES = 8,
  localparam int CNT_W = $clog2(WIN_BYTES + 1)
) (
  input  logic [WIN_BYTES-1:0][7:0]  win_bytes,
  input  logic [CNT_W-1:0]           run_len,
  output logic                       hit_tri,
  output logic                       hit_sl,
  output logic                       hit_as,
  output fuse_pkg::fkind_e           kind,
  output logic [CNT_W-1:0]           len,
  output logic [fuse_pkg::OPND_W-1:0] addr_a,
  output logic [fuse_pkg::OPND_W-1:0] addr_b,
  output logic [1:0]                 n_acc,
  output logic                       beyond,
  output logic                       carry_clr
);
  import fuse_pkg::*;

  logic [7:0] b0, b1, b2, b3, b4, b5, b6;
  assign b0 = win_bytes[0];
  assign b1 = win_bytes[1];
  assign b2 = win_bytes[2];
  assign b3 = win_bytes[3];
  assign b4 = win_bytes[4];
  assign b5 = win_bytes[5];
  assign b6 = win_bytes[6];

  logic tri_room, pair_room;
  assign tri_room  = run_len >= CNT_W'(TRI_LEN);
  assign pair_room = run_len >= CNT_W'(PAIR_LEN);

  // raw pattern hits, brought out for checking
  assign hit_tri = tri_room  && (b0 == OPC_CLC) && (b1 == OPC_LDA) && (b4 == OPC_ADC);
  assign hit_sl  = pair_room && (b0 == OPC_STA) && (b3 == OPC_LDA);
  assign hit_as  = pair_room && (b0 == OPC_ADC) && (b3 == OPC_STA);

  logic [3:0] single_len;
  assign single_len = op_len(b0);

  // longest pattern first, then pairs, then single fallback
  always_comb begin
    kind      = FK_NONE;
    len       = '0;
    addr_a    = '0;
    addr_b    = '0;
    n_acc     = 2'd0;
    beyond    = 1'b0;
    carry_clr = 1'b0;
    if (hit_tri) begin
      kind      = FK_ADD;
      len       = CNT_W'(TRI_LEN);
      addr_a    = le16(b2, b3);
      addr_b    = le16(b5, b6);
      n_acc     = 2'd2;
      carry_clr = 1'b1;
    end else if (hit_sl) begin
      kind   = FK_STLD;
      len    = CNT_W'(PAIR_LEN);
      addr_a = le16(b1, b2);
      addr_b = le16(b4, b5);
      n_acc  = 2'd2;
    end else if (hit_as) begin
      kind   = FK_ADST;
      len    = CNT_W'(PAIR_LEN);
      addr_a = le16(b1, b2);
      addr_b = le16(b4, b5);
      n_acc  = 2'd2;
    end else if (run_len != '0) begin
      kind   = FK_SINGLE;
      len    = CNT_W'(single_len);
      beyond = CNT_W'(single_len) > run_len;
      if (is_abs(b0)) begin
        addr_a = le16(b1, b2);
        n_acc  = 2'd1;
      end
    end
  end

endmodule

// File: rtl/fuse_cost.sv
module fuse_cost #(
  parameter int COST_W = 4
) (
  input  fuse_pkg::fkind_e            kind,
  input  logic [1:0]                  n_acc,
  input  logic [fuse_pkg::OPND_W-1:0] addr_a,
  input  logic [fuse_pkg::OPND_W-1:0] addr_b,
  input  logic                        acc16,
  input  logic                        beyond,
  output logic                        str_a,
  output logic                        str_b,
  output logic [COST_W-1:0]           cost
);
  import fuse_pkg::*;

  assign str_a = (n_acc >= 2'd1) && crosses_line(addr_a, acc16);
  assign str_b = (n_acc == 2'd2) && crosses_line(addr_b, acc16);

  always_comb begin
    if (kind == FK_NONE) begin
      cost = '0;
    end else begin
      cost = COST_W'(1) + COST_W'(n_acc) + COST_W'(str_a) + COST_W'(str_b)
           + COST_W'(beyond);
    end
  end

endmodule

// File: rtl/fuse_detect.sv
module fuse_detect #(
  parameter int WIN_BYTES = 8,
  parameter int ADDR_W    = 16,
  parameter int COST_W    = 4,
  localparam int CNT_W    = $clog2(WIN_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [8*WIN_BYTES-1:0]  win_data,
  input  logic [WIN_BYTES-1:0]    byte_valid,
  input  logic [ADDR_W-1:0]       win_base,
  input  logic                    acc16,
  output logic [2:0]              fused_kind,
  output logic [CNT_W-1:0]        fused_len,
  output logic [COST_W-1:0]       fused_cost,
  output logic [15:0]             opnd_a,
  output logic [15:0]             opnd_b,
  output logic                    carry_clr,
  output logic [ADDR_W-1:0]       next_addr
);
  import fuse_pkg::*;

  logic [WIN_BYTES-1:0][7:0] win_bytes;
  logic [CNT_W-1:0]          run_len;

  fuse_scan #(.WIN_BYTES(WIN_BYTES)) scan_i (
    .win_data   (win_data),
    .byte_valid (byte_valid),
    .win_bytes  (win_bytes),
    .run_len    (run_len)
  );

  logic              hit_tri, hit_sl, hit_as;
  fkind_e            m_kind;
  logic [CNT_W-1:0]  m_len;
  logic [OPND_W-1:0] m_a, m_b;
  logic [1:0]        m_nacc;
  logic              m_beyond, m_cclr;

  fuse_match #(.WIN_BYTES(WIN_BYTES)) match_i (
    .win_bytes (win_bytes),
    .run_len   (run_len),
    .hit_tri   (hit_tri),
    .hit_sl    (hit_sl),
    .hit_as    (hit_as),
    .kind      (m_kind),
    .len       (m_len),
    .addr_a    (m_a),
    .addr_b    (m_b),
    .n_acc     (m_nacc),
    .beyond    (m_beyond),
    .carry_clr (m_cclr)
  );

  logic              str_a, str_b;
  logic [COST_W-1:0] m_cost;

  fuse_cost #(.COST_W(COST_W)) cost_i (
    .kind   (m_kind),
    .n_acc  (m_nacc),
    .addr_a (m_a),
    .addr_b (m_b),
    .acc16  (acc16),
    .beyond (m_beyond),
    .str_a  (str_a),
    .str_b  (str_b),
    .cost   (m_cost)
  );

  logic [ADDR_W-1:0] m_next;
  assign m_next = win_base + ADDR_W'(m_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fused_kind <= 3'(FK_NONE);
      fused_len  <= '0;
      fused_cost <= '0;
      opnd_a     <= '0;
      opnd_b     <= '0;
      carry_clr  <= 1'b0;
      next_addr  <= '0;
    end else begin
      fused_kind <= 3'(m_kind);
      fused_len  <= m_len;
      fused_cost <= m_cost;
      opnd_a     <= m_a;
      opnd_b     <= m_b;
      carry_clr  <= m_cclr;
      next_addr  <= m_next;
    end
  end

endmodule

// File: rtl/fuse_detect_chk.sv
module fuse_detect_chk #(
  parameter int WIN_BYTES = 8,
  parameter int ADDR_W    = 16,
  parameter int COST_W    = 4,
  localparam int CNT_W    = $clog2(WIN_BYTES + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [WIN_BYTES-1:0] byte_valid,
  input logic [ADDR_W-1:0]    win_base,
  input logic                 acc16,
  input logic                 hit_tri,
  input logic                 hit_sl,
  input logic                 hit_as,
  input logic [2:0]           fused_kind,
  input logic [CNT_W-1:0]     fused_len,
  input logic [COST_W-1:0]    fused_cost,
  input logic                 carry_clr,
  input logic [ADDR_W-1:0]    next_addr
);

  // R2
  tri_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_tri |=> (fused_kind == 3'd2) && (fused_len == CNT_W'(7)) && carry_clr);

  // R2
  carry_only_tri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_clr |-> (fused_kind == 3'd2));

  // R3
  store_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_sl && !hit_tri) |=> (fused_kind == 3'd3) && (fused_len == CNT_W'(6)));

  // R4
  add_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_as && !hit_tri) |=> (fused_kind == 3'd4) && (fused_len == CNT_W'(6)));

  // R5
  single_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fused_kind == 3'd1) |-> (fused_len == CNT_W'(1)) || (fused_len == CNT_W'(3)));

  // R6
  empty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid[0] |=> (fused_kind == 3'd0) && (fused_len == '0) && (fused_cost == '0));

  // R7
  cost_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fused_kind != 3'd0) |-> (fused_cost >= COST_W'(1)) && (fused_cost <= COST_W'(5)));

  // R8
  narrow_fused_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc16 && (hit_tri || hit_sl || hit_as)) |=> (fused_cost == COST_W'(3)));

  // R10
  next_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (next_addr == $past(win_base) + ADDR_W'(fused_len)));

endmodule

bind fuse_detect fuse_detect_chk #(
  .WIN_BYTES (WIN_BYTES),
  .ADDR_W    (ADDR_W),
  .COST_W    (COST_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_valid (byte_valid),
  .win_base   (win_base),
  .acc16      (acc16),
  .hit_tri    (hit_tri),
  .hit_sl     (hit_sl),
  .hit_as     (hit_as),
  .fused_kind (fused_kind),
  .fused_len  (fused_len),
  .fused_cost (fused_cost),
  .carry_clr  (carry_clr),
  .next_addr  (next_addr)
);

// File: tb/fuse_detect_tb.sv
`timescale 1ns/1ps
module fuse_detect_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] win_data = '0;
  logic [7:0]  byte_valid = '0;
  logic [15:0] win_base = '0;
  logic        acc16 = 1'b0;
  logic [2:0]  fused_kind;
  logic [3:0]  fused_len;
  logic [3:0]  fused_cost;
  logic [15:0] opnd_a, opnd_b;
  logic        carry_clr;
  logic [15:0] next_addr;

  always #2 clk = ~clk;

  fuse_detect dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_data   (win_data),
    .byte_valid (byte_valid),
    .win_base   (win_base),
    .acc16      (acc16),
    .fused_kind (fused_kind),
    .fused_len  (fused_len),
    .fused_cost (fused_cost),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .carry_clr  (carry_clr),
    .next_addr  (next_addr)
  );

  typedef struct packed {
    logic [63:0] data;
    logic [7:0]  vld;
    logic [15:0] base;
    logic        acc;
    logic [2:0]  kind;
    logic [3:0]  len;
    logic [3:0]  cost;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] nxt;
    logic        cc;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    // 0 R2 triple, 8-bit
    '{64'h0056_786D_1234_AD18, 8'hFF, 16'h1000, 1'b0, 3'd2, 4'd7, 4'd3, 16'h1234, 16'h5678, 16'h1007, 1'b1},
    // 1 R8 triple, 16-bit, both operands straddle
    '{64'h0056_7F6D_1237_AD18, 8'hFF, 16'h1000, 1'b1, 3'd2, 4'd7, 4'd5, 16'h1237, 16'h567F, 16'h1007, 1'b1},
    // 2 R8 same addresses, 8-bit: no straddle penalty
    '{64'h0056_7F6D_1237_AD18, 8'hFF, 16'h1000, 1'b0, 3'd2, 4'd7, 4'd3, 16'h1237, 16'h567F, 16'h1007, 1'b1},
    // 3 R5 triple one byte short -> single clear-carry
    '{64'h0056_786D_1234_AD18, 8'h3F, 16'h1000, 1'b0, 3'd1, 4'd1, 4'd1, 16'h0000, 16'h0000, 16'h1001, 1'b0},
    // 4 R3 store-load, 16-bit, aligned
    '{64'hEAEA_2008_AD20_008D, 8'hFF, 16'h0200, 1'b1, 3'd3, 4'd6, 4'd3, 16'h2000, 16'h2008, 16'h0206, 1'b0},
    // 5 R4 add-store with exactly 6 valid, first operand straddles
    '{64'h0000_3010_8D30_076D, 8'h3F, 16'h0400, 1'b1, 3'd4, 4'd6, 4'd4, 16'h3007, 16'h3010, 16'h0406, 1'b0},
    // 6 R5 add-store one byte short -> single add
    '{64'h0000_3010_8D30_076D, 8'h1F, 16'h0400, 1'b1, 3'd1, 4'd3, 4'd3, 16'h3007, 16'h0000, 16'h0403, 1'b0},
    // 7 R9 truncated load, zero-filled operand, address wrap
    '{64'h0000_0000_0012_34AD, 8'h03, 16'hFFFE, 1'b0, 3'd1, 4'd3, 4'd3, 16'h0034, 16'h0000, 16'h0001, 1'b0},
    // 8 R5 unknown opcode
    '{64'hADAD_ADAD_ADAD_ADEA, 8'hFF, 16'h0010, 1'b1, 3'd1, 4'd1, 4'd1, 16'h0000, 16'h0000, 16'h0011, 1'b0},
    // 9 R6 empty window
    '{64'h0056_786D_1234_AD18, 8'h00, 16'h0123, 1'b1, 3'd0, 4'd0, 4'd0, 16'h0000, 16'h0000, 16'h0123, 1'b0},
    // 10 R6 hole in valid mask at byte 3
    '{64'h0056_786D_1234_AD18, 8'hF7, 16'h1000, 1'b0, 3'd1, 4'd1, 4'd1, 16'h0000, 16'h0000, 16'h1001, 1'b0},
    // 11 R5 store not followed by load
    '{64'h0000_1111_8D20_008D, 8'hFF, 16'h0300, 1'b0, 3'd1, 4'd3, 4'd2, 16'h2000, 16'h0000, 16'h0303, 1'b0},
    // 12 R2 third opcode wrong -> single clear-carry
    '{64'h0056_78AD_1234_AD18, 8'hFF, 16'h0500, 1'b0, 3'd1, 4'd1, 4'd1, 16'h0000, 16'h0000, 16'h0501, 1'b0},
    // 13 R9 truncated load, 16-bit straddle plus fetch penalty
    '{64'h0000_0000_0012_FFAD, 8'h03, 16'h0600, 1'b1, 3'd1, 4'd3, 4'd4, 16'h00FF, 16'h0000, 16'h0603, 1'b0},
    // 14 R7 store-load, second operand straddles
    '{64'h0000_400F_AD40_108D, 8'h3F, 16'h0700, 1'b1, 3'd3, 4'd6, 4'd4, 16'h4010, 16'h400F, 16'h0706, 1'b0}
  };

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    win_data   = v.data;
    byte_valid = v.vld;
    win_base   = v.base;
    acc16      = v.acc;
  endtask

  task automatic check_vec(input vec_t v, input int idx);
    string tag;
    tag = $sformatf("vec%0d", idx);
    chk({"R2 R3 R4 R5 R6 ", tag}, "kind", 32'(fused_kind), 32'(v.kind));
    chk({"R2 R3 R4 R5 R6 ", tag}, "len",  32'(fused_len),  32'(v.len));
    chk({"R7 R8 R9 ", tag},       "cost", 32'(fused_cost), 32'(v.cost));
    chk({"R2 R3 R5 R9 ", tag},    "opnd_a", 32'(opnd_a),   32'(v.a));
    chk({"R2 R3 R5 ", tag},       "opnd_b", 32'(opnd_b),   32'(v.b));
    chk({"R2 ", tag},             "carry_clr", 32'(carry_clr), 32'(v.cc));
    chk({"R10 ", tag},            "next_addr", 32'(next_addr), 32'(v.nxt));
  endtask

  task automatic check_zero(input string req);
    chk(req, "kind", 32'(fused_kind), 32'd0);
    chk(req, "len",  32'(fused_len),  32'd0);
    chk(req, "cost", 32'(fused_cost), 32'd0);
    chk(req, "opnd_a", 32'(opnd_a), 32'd0);
    chk(req, "opnd_b", 32'(opnd_b), 32'd0);
    chk(req, "carry_clr", 32'(carry_clr), 32'd0);
    chk(req, "next_addr", 32'(next_addr), 32'd0);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R1 reset state, inputs already carrying a matching triple
    apply(VECS[0]);
    repeat (3) @(negedge clk);
    check_zero("R1 in reset");
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VECS[i]);
      @(negedge clk);
      check_vec(VECS[i], i);
    end

    // R11: outputs hold until the next edge
    @(negedge clk);
    apply(VECS[9]);
    @(negedge clk);
    apply(VECS[0]);
    #1;
    chk("R11 before edge", "kind", 32'(fused_kind), 32'd0);
    chk("R11 before edge", "next_addr", 32'(next_addr), 32'h0123);
    @(negedge clk);
    chk("R11 after edge", "kind", 32'(fused_kind), 32'd2);
    chk("R11 after edge", "next_addr", 32'(next_addr), 32'h1007);

    // R1: asynchronous reset in the middle of operation
    rst_n = 1'b0;
    #1;
    check_zero("R1 async");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_vec(VECS[0], 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule